// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns a bank of already-synchronized input pin levels into interrupt requests. Every pin carries its own configuration: whether it is armed, whether its request is hidden from the processor, whether it reacts to edges or to levels, which edge or level is active, whether both edges count, and whether its input first passes a debounce filter. Edge events are held in a sticky status bit until software pulses the pin's clear bit. Level events simply track the pin.

The block drives three outputs. The first is a raw status vector. The second is a masked status vector that keeps only armed, unhidden pins. The third is a single request line, which is the OR of the masked vector. Register storage and the bus interface sit outside the block. The configuration arrives as plain vectors. The clear arrives as a one-cycle pulse vector. Bit i of every vector belongs to pin i.

Top module: `irq_pin_detector`

## Requirements
- R1: While reset is held, and in the first cycle after it, with all configuration zero, raw status, masked status and the request line are all 0. The debounce filter outputs and the stored previous levels reset to 0.
- R2: cfg_edge bit = 1 makes a pin edge-sensitive, so its raw bit latches and stays set after the pin returns. cfg_edge bit = 0 makes it level-sensitive, so its raw bit follows the pin.
- R3: On an edge pin with cfg_both = 0, cfg_pol = 1 latches on a 0→1 transition only, and cfg_pol = 0 latches on a 1→0 transition only.
- R4: On a level pin, the raw bit is 1 when the pin is armed and its level equals cfg_pol (1 = active-high, 0 = active-low).
- R5: On an edge pin with cfg_both = 1, both transitions latch, whatever the value of cfg_pol.
- R6: A 1 in eoi_clr clears that pin's latched edge status in the following cycle. On a level pin it has no effect.
- R7: When an edge and its eoi_clr bit fall in the same cycle, the edge wins and the status stays set.
- R8: An edge latches only while cfg_en is 1. Dropping cfg_en clears the latched bit at the next clock edge, and re-arming does not bring it back. cfg_mask does not stop raw latching.
- R9: irq_stat = raw_stat AND cfg_en AND NOT cfg_mask, and irq_out is the OR of irq_stat.
- R10: With cfg_dbnc = 1, a pin change passes the filter only after 4 consecutive samples of the new value, taken on a tick every TICK_DIV clocks (default 4). A shorter pulse is dropped.
- R11: An edge is the filtered level compared with its value one clock earlier. The pin's status shows the change after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NPINS | Synchronized pin levels |
| cfg_en | input | NPINS | Per-pin arm bits |
| cfg_mask | input | NPINS | Per-pin hide bits (1 hides from irq_out) |
| cfg_edge | input | NPINS | 1 = edge-sensitive, 0 = level-sensitive |
| cfg_pol | input | NPINS | Edge: 1 rising / 0 falling; level: 1 high / 0 low |
| cfg_both | input | NPINS | 1 = both edges latch (edge pins) |
| cfg_dbnc | input | NPINS | 1 = route pin through the debounce filter |
| eoi_clr | input | NPINS | One-cycle pulse, clears latched edge status |
| raw_stat | output | NPINS | Raw status per pin |
| irq_stat | output | NPINS | Masked status per pin |
| irq_out | output | 1 | Combined request line |

## Verification
A new edge on a pin and the clear pulse for that same pin can land in one cycle. The clear must lose. The stimulus table raises pin 0 in the very cycle that pulses its eoi_clr bit, and the check expects the status to stay set. A later step then clears the pin with no edge present, which shows that the clear itself works. A second collision is an edge that arrives while the pin's arm bit is dropped. The bench disarms a latched pin, then re-arms it, and judges that the status stays clear until a fresh edge comes.

// File: rtl/irq_pin_pkg.sv
// Shared types for the per-pin interrupt detector.
package irq_pin_pkg;

    // Per-pin trigger configuration as seen by one trigger cell.
    typedef struct packed {
        logic en;
        logic edge_mode;
        logic pol;
        logic both;
    } trig_cfg_t;

endpackage

// File: rtl/irq_tick_gen.sv
// Slow sample tick for the debounce filters.
// Emits a one-clock pulse every DIV clocks. Assumes DIV >= 1.
module irq_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [TW-1:0] div_cnt;

    // Count clocks and wrap at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                         div_cnt <= '0;
        else if (div_cnt == TW'(DIV - 1))   div_cnt <= '0;
        else                                div_cnt <= div_cnt + 1'b1;
    end

    // Tick on the last count of each period.
    always_comb tick = (div_cnt == TW'(DIV - 1));
endmodule

// File: rtl/irq_pin_filter.sv
// Debounce filter for one pin.
// The output takes a new value only after STABLE consecutive tick samples
// differ from it. Assumes the input is already synchronous to clk.
module irq_pin_filter #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE) + 1;

    logic [CW-1:0] run_cnt;
    logic          held;

    // Count differing samples and accept the change on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= 1'b0;
            run_cnt <= '0;
        end else if (tick) begin
            if (din == held) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(STABLE - 1)) begin
                held    <= din;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Present the accepted level.
    always_comb dout = held;
endmodule

// File: rtl/irq_pin_trigger.sv
// Trigger cell for one pin.
// Detects edges against the level seen one clock earlier and holds edge
// events until cleared. Level mode reports the live match. Assumes lvl is
// already filtered when filtering is wanted.
module irq_pin_trigger
    import irq_pin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      raw
);
    logic prev_lvl;
    logic hit;
    logic sticky;
    logic rise;
    logic fall;

    // Remember the level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= lvl;
    end

    // Classify the transition and apply polarity or both-edge selection.
    always_comb begin
        rise = lvl & ~prev_lvl;
        fall = ~lvl & prev_lvl;
        if (cfg.both) hit = rise | fall;
        else          hit = cfg.pol ? rise : fall;
    end

    // Sticky edge status: disarm clears, a new edge beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sticky <= 1'b0;
        else if (!cfg.en || !cfg.edge_mode) sticky <= 1'b0;
        else if (hit)                       sticky <= 1'b1;
        else if (clr)                       sticky <= 1'b0;
    end

    // Pick the sticky bit in edge mode and the armed level match otherwise.
    always_comb begin
        if (cfg.edge_mode) raw = sticky;
        else               raw = cfg.en & (lvl == cfg.pol);
    end
endmodule

// File: rtl/irq_pin_detector.sv
// Per-pin interrupt detector, top level.
// Builds one filter and one trigger cell per pin, gates the status with arm
// and hide bits, and ORs the result into one request line. Assumes pin_lvl
// is already synchronized and eoi_clr is a one-cycle pulse.
module irq_pin_detector
    import irq_pin_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int TICK_DIV = 4,
    parameter int STABLE   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] cfg_en,
    input  logic [NPINS-1:0] cfg_mask,
    input  logic [NPINS-1:0] cfg_edge,
    input  logic [NPINS-1:0] cfg_pol,
    input  logic [NPINS-1:0] cfg_both,
    input  logic [NPINS-1:0] cfg_dbnc,
    input  logic [NPINS-1:0] eoi_clr,
    output logic [NPINS-1:0] raw_stat,
    output logic [NPINS-1:0] irq_stat,
    output logic             irq_out
);
    logic             slow_tick;
    logic [NPINS-1:0] filt_lvl;
    logic [NPINS-1:0] sel_lvl;

    irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_cfg_t cell_cfg;

        irq_pin_filter #(.STABLE(STABLE)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (slow_tick),
            .din   (pin_lvl[p]),
            .dout  (filt_lvl[p])
        );

        // Choose the filtered or the direct level and pack the cell config.
        always_comb begin
            sel_lvl[p]         = cfg_dbnc[p] ? filt_lvl[p] : pin_lvl[p];
            cell_cfg.en        = cfg_en[p];
            cell_cfg.edge_mode = cfg_edge[p];
            cell_cfg.pol       = cfg_pol[p];
            cell_cfg.both      = cfg_both[p];
        end

        irq_pin_trigger u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (sel_lvl[p]),
            .cfg   (cell_cfg),
            .clr   (eoi_clr[p]),
            .raw   (raw_stat[p])
        );
    end

    // Gate the status with arm and hide bits, then merge into one line.
    always_comb begin
        irq_stat = raw_stat & cfg_en & ~cfg_mask;
        irq_out  = |irq_stat;
    end
endmodule

// File: rtl/irq_pin_detector_chk.sv
// Checker for the per-pin interrupt detector, attached through bind.
module irq_pin_detector_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] cfg_en,
    input logic [NPINS-1:0] cfg_mask,
    input logic [NPINS-1:0] cfg_edge,
    input logic [NPINS-1:0] eoi_clr,
    input logic [NPINS-1:0] raw_stat,
    input logic [NPINS-1:0] irq_stat,
    input logic             irq_out
);
    // R9: a masked status bit never appears without its raw bit.
    a_r9_masked_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & ~raw_stat) == '0);

    // R9: hidden or disarmed pins never reach the masked vector.
    a_r9_hidden_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & (~cfg_en | cfg_mask)) == '0);

    // R9: the request line is high only with some masked bit set.
    a_r9_line_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_stat != '0));

    // R8: an edge pin disarmed one clock ago shows no status.
    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat & cfg_edge & $past(cfg_edge) & ~$past(cfg_en)) == '0);

    // R6: a latched, armed edge pin without a clear stays latched.
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_stat & cfg_edge & cfg_en & ~eoi_clr) & cfg_edge & $past(cfg_edge)
         & ~raw_stat) == '0);
endmodule

bind irq_pin_detector irq_pin_detector_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_mask (cfg_mask),
    .cfg_edge (cfg_edge),
    .eoi_clr  (eoi_clr),
    .raw_stat (raw_stat),
    .irq_stat (irq_stat),
    .irq_out  (irq_out)
);

// File: tb/tb_irq_pin_detector.sv
module tb_irq_pin_detector;
    localparam int N = 32;

    typedef struct packed {
        logic [31:0] pins;
        logic [31:0] eoi;
        logic [31:0] raw;
        logic [31:0] irq;
    } step_t;

    // Pins 0..3 edge: rise, fall, both(pol0), both(pol1); 4 high level; 5 low level;
    // 6 rising but hidden; 7 rising but disarmed.
    localparam step_t STEPS [9] = '{
        '{32'h00, 32'h00, 32'h20, 32'h20}, // R4 low-level active
        '{32'hFF, 32'h00, 32'h5D, 32'h1D}, // R3 R5 R8 rising
        '{32'h00, 32'h00, 32'h6F, 32'h2F}, // R2 R3 falling, latches held
        '{32'h00, 32'hFF, 32'h20, 32'h20}, // R6 clear, level pin untouched
        '{32'h0F, 32'h01, 32'h2D, 32'h2D}, // R7 edge beats clear on pin 0
        '{32'h0F, 32'h0C, 32'h21, 32'h21}, // R6 clear pins 2,3
        '{32'h0F, 32'h01, 32'h20, 32'h20}, // R6 clear pin 0
        '{32'h30, 32'h00, 32'h1E, 32'h1E}, // R4 R5 falling, high level
        '{32'h30, 32'h0E, 32'h10, 32'h10}  // R6 R9
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0, cfg_en = '0, cfg_mask = '0, cfg_edge = '0;
    logic [N-1:0] cfg_pol = '0, cfg_both = '0, cfg_dbnc = '0, eoi_clr = '0;
    logic [N-1:0] raw_stat, irq_stat;
    logic         irq_out;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    irq_pin_detector #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_en(cfg_en),
        .cfg_mask(cfg_mask), .cfg_edge(cfg_edge), .cfg_pol(cfg_pol),
        .cfg_both(cfg_both), .cfg_dbnc(cfg_dbnc), .eoi_clr(eoi_clr),
        .raw_stat(raw_stat), .irq_stat(irq_stat), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R1 raw in reset", raw_stat, '0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 raw after reset", raw_stat, '0);
        check("R1 irq_stat after reset", irq_stat, '0);
        check("R1 irq_out after reset", {31'b0, irq_out}, '0);

        cfg_en   = 32'h7F;
        cfg_mask = 32'h40;
        cfg_edge = 32'hCF;
        cfg_pol  = 32'hD9;
        cfg_both = 32'h0C;
        for (int s = 0; s < 9; s++) begin
            pin_lvl = STEPS[s].pins;
            eoi_clr = STEPS[s].eoi;
            cyc(1);
            check($sformatf("R2/R9 step %0d raw", s), raw_stat, STEPS[s].raw);
            check($sformatf("R9 step %0d irq_stat", s), irq_stat, STEPS[s].irq);
            check($sformatf("R9 step %0d irq_out", s), {31'b0, irq_out},
                  {31'b0, STEPS[s].irq != 0});
        end
        eoi_clr = '0;

        // R8 and R11: latch pin 0, disarm, re-arm.
        pin_lvl = 32'h31;
        cyc(1);
        check("R11 edge visible next clock", raw_stat, 32'h11);
        cfg_en = 32'h7E;
        cyc(1);
        check("R8 disarm clears", raw_stat, 32'h10);
        cfg_en = 32'h7F;
        cyc(2);
        check("R8 re-arm does not restore", raw_stat, 32'h10);

        // R10: debounced rising edge on pin 8.
        cfg_en[8] = 1'b1; cfg_edge[8] = 1'b1; cfg_pol[8] = 1'b1; cfg_dbnc[8] = 1'b1;
        pin_lvl[8] = 1'b1;
        cyc(6);
        pin_lvl[8] = 1'b0;
        cyc(20);
        check("R10 short pulse dropped", raw_stat & 32'h100, '0);
        pin_lvl[8] = 1'b1;
        cyc(8);
        check("R10 not passed before 4 ticks", raw_stat & 32'h100, '0);
        cyc(20);
        check("R10 stable input passes", raw_stat & 32'h100, 32'h100);
        check("R10 masked status", irq_stat & 32'h100, 32'h100);
        check("R10 line raised", {31'b0, irq_out}, 32'h1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule